// File: doc/BRIEF.md
# Read-only Fuse Row Cache Window

This block is a memory-mapped read-only slave placed in front of a fuse array stored as 32-bit rows. A requester presents a byte address and an access size of one to four bytes on a valid/ready request channel. The block then reads the row, or the two adjacent rows, that hold those bytes through a synchronous row-read port. It joins them into a 64-bit little-endian value, shifts the first requested byte down to bit 0, and zeroes every byte past the requested size.

Writes are never carried out. Each write gets an error response and sets a guest-error flag that holds until reset. A request whose size is illegal gets an error response with zero data and no row traffic. So does a request that reaches past the end of the 3072-byte window.

Top module: `fuse_row_window`

## Requirements
- R1: A read whose last byte (address + size - 1) is at or above byte 3072 (0xC00) gets rsp_err = 1 and rsp_data = 0, and issues no row read.
- R2: Only req_size values 1, 2, 3 and 4 are legal. Any other value gets rsp_err = 1 and rsp_data = 0, and issues no row read.
- R3: A legal read issues row index address>>2 first. If (address + size - 1)>>2 differs from it, that index is issued next.
- R4: A read issues exactly one row read when its bytes lie in one row and exactly two when they straddle a row boundary, never more.
- R5: Byte k of rsp_data (bits 8k+7:8k) equals array byte address + k. Array byte b is bits 8*(b mod 4)+7 : 8*(b mod 4) of row b>>2.
- R6: Bytes of rsp_data at positions at or beyond req_size read as zero.
- R7: A write gets rsp_err = 1 with zero data and issues no row read. It sets guest_err, which stays set through later requests.
- R8: rsp_valid is high for exactly one cycle. Counting the accepting edge as cycle 0, it appears 1 cycle later for an error, 3 for a one-row read and 4 for a two-row read. req_ready is low from acceptance through the response cycle.
- R9: A synchronous active-high reset returns the block to idle: req_ready = 1, rsp_valid = 0 and guest_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | Request is a write (always refused) |
| req_addr | input | ADDR_W (16) | Byte address |
| req_size | input | SIZE_W (3) | Access size in bytes |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 32 | Aligned, masked read data |
| guest_err | output | 1 | Sticky flag: a write was refused |
| row_rd_en | output | 1 | Row read strobe |
| row_rd_idx | output | IDX_W (10) | Row index to read |
| row_rd_data | input | 32 | Row contents, valid the cycle after the strobe |

## Verification
The hardest cases to reach are the two-row straddles: unaligned starts where the access runs past a 32-bit row boundary. The same applies near the top of the window, where a straddle becomes an out-of-range error. The bench sweeps every start offset with every size, including the illegal ones. It repeats the sweep over the last rows below 0xC00, where the last byte crosses the window edge. For each access it checks the order of row indices, the number of row reads and the response latency, along with the data.

// File: rtl/fuse_win_pkg.sv
package fuse_win_pkg;

  localparam int unsigned FW_ROW_BITS  = 32;
  localparam int unsigned FW_ROW_BYTES = FW_ROW_BITS / 8;

  typedef enum logic [2:0] {
    FW_IDLE,
    FW_ISSUE_LO,
    FW_ISSUE_HI,
    FW_LAST,
    FW_RESP
  } fw_state_e;

  // Place the higher row above the lower one; a one-row access leaves the top half empty.
  function automatic logic [2*FW_ROW_BITS-1:0] fw_merge(
    input logic [FW_ROW_BITS-1:0] lo,
    input logic [FW_ROW_BITS-1:0] hi,
    input logic                   two
  );
    return two ? {hi, lo} : {{FW_ROW_BITS{1'b0}}, lo};
  endfunction

  // Keep only the requested number of bytes.
  function automatic logic [FW_ROW_BITS-1:0] fw_byte_mask(input logic [2:0] nbytes);
    logic [FW_ROW_BITS-1:0] m;
    m = '0;
    for (int k = 0; k < FW_ROW_BYTES; k++) begin
      if (k < int'(nbytes)) m[8*k +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/fuse_win_decode.sv
module fuse_win_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned WIN_BYTES = 3072,
  parameter int unsigned IDX_W     = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic              bad,
  output logic              two_row,
  output logic [IDX_W-1:0]  lo_idx,
  output logic [IDX_W-1:0]  hi_idx,
  output logic [1:0]        byte_off
);
  localparam int unsigned EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] last_byte;
  logic             size_ok;
  logic             range_ok;

  always_comb begin
    last_byte = {1'b0, addr} + EXT_W'(size) - EXT_W'(1);
    size_ok   = (size >= SIZE_W'(1)) && (size <= SIZE_W'(4));
    range_ok  = last_byte < EXT_W'(WIN_BYTES);
    bad       = !size_ok || !range_ok;
    two_row   = {1'b0, addr[ADDR_W-1:2]} != last_byte[EXT_W-1:2];
    lo_idx    = addr[IDX_W+1:2];
    hi_idx    = last_byte[IDX_W+1:2];
    byte_off  = addr[1:0];
  end
endmodule

// File: rtl/fuse_win_seq.sv
module fuse_win_seq
  import fuse_win_pkg::*;
#(
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned IDX_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  logic                   refuse,
  input  logic                   d_two,
  input  logic [IDX_W-1:0]       d_lo_idx,
  input  logic [IDX_W-1:0]       d_hi_idx,
  input  logic [1:0]             d_off,
  input  logic [SIZE_W-1:0]      d_size,
  input  logic [FW_ROW_BITS-1:0] row_rd_data,
  output fw_state_e              state,
  output logic                   row_rd_en,
  output logic [IDX_W-1:0]       row_rd_idx,
  output logic [FW_ROW_BITS-1:0] lo_row,
  output logic [FW_ROW_BITS-1:0] hi_row,
  output logic                   two_q,
  output logic                   err_q,
  output logic [1:0]             off_q,
  output logic [SIZE_W-1:0]      size_q
);
  fw_state_e        state_q;
  logic [IDX_W-1:0] lo_idx_q;
  logic [IDX_W-1:0] hi_idx_q;

  assign state      = state_q;
  assign row_rd_en  = (state_q == FW_ISSUE_LO) || (state_q == FW_ISSUE_HI);
  assign row_rd_idx = (state_q == FW_ISSUE_HI) ? hi_idx_q : lo_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= FW_IDLE;
      lo_idx_q <= '0;
      hi_idx_q <= '0;
      lo_row   <= '0;
      hi_row   <= '0;
      two_q    <= 1'b0;
      err_q    <= 1'b0;
      off_q    <= '0;
      size_q   <= '0;
    end else begin
      unique case (state_q)
        FW_IDLE: begin
          if (accept) begin
            lo_idx_q <= d_lo_idx;
            hi_idx_q <= d_hi_idx;
            two_q    <= d_two;
            off_q    <= d_off;
            size_q   <= d_size;
            err_q    <= refuse;
            state_q  <= refuse ? FW_RESP : FW_ISSUE_LO;
          end
        end
        FW_ISSUE_LO: state_q <= two_q ? FW_ISSUE_HI : FW_LAST;
        FW_ISSUE_HI: begin
          lo_row  <= row_rd_data;
          state_q <= FW_LAST;
        end
        FW_LAST: begin
          if (two_q) hi_row <= row_rd_data;
          else       lo_row <= row_rd_data;
          state_q <= FW_RESP;
        end
        FW_RESP: state_q <= FW_IDLE;
        default: state_q <= FW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_win_align.sv
module fuse_win_align
  import fuse_win_pkg::*;
#(
  parameter int unsigned SIZE_W = 3
) (
  input  logic [FW_ROW_BITS-1:0] lo_row,
  input  logic [FW_ROW_BITS-1:0] hi_row,
  input  logic                   two,
  input  logic [1:0]             off,
  input  logic [SIZE_W-1:0]      size,
  input  logic                   err,
  output logic [FW_ROW_BITS-1:0] data
);
  logic [2*FW_ROW_BITS-1:0] merged;
  logic [2*FW_ROW_BITS-1:0] shifted;

  always_comb begin
    merged  = fw_merge(lo_row, hi_row, two);
    shifted = merged >> {off, 3'b000};
    data    = err ? '0 : (shifted[FW_ROW_BITS-1:0] & fw_byte_mask(3'(size)));
  end
endmodule

// File: rtl/fuse_row_window.sv
module fuse_row_window
  import fuse_win_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned WIN_BYTES = 3072,
  parameter int unsigned IDX_W     = $clog2(WIN_BYTES / FW_ROW_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [SIZE_W-1:0]      req_size,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [FW_ROW_BITS-1:0] rsp_data,
  output logic                   guest_err,
  output logic                   row_rd_en,
  output logic [IDX_W-1:0]       row_rd_idx,
  input  logic [FW_ROW_BITS-1:0] row_rd_data
);
  fw_state_e              state;
  logic                   accept, accept_wr, accept_rd, refuse;
  logic                   d_bad, d_two;
  logic [IDX_W-1:0]       d_lo_idx, d_hi_idx;
  logic [1:0]             d_off;
  logic [FW_ROW_BITS-1:0] lo_row, hi_row, aligned;
  logic                   two_q, err_q;
  logic [1:0]             off_q;
  logic [SIZE_W-1:0]      size_q;
  logic                   flag_q;

  assign req_ready = (state == FW_IDLE);
  assign accept    = req_valid && req_ready;
  assign accept_wr = accept && req_write;
  assign accept_rd = accept && !req_write;
  assign refuse    = req_write || d_bad;

  fuse_win_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .WIN_BYTES(WIN_BYTES), .IDX_W(IDX_W)
  ) u_decode (
    .addr(req_addr), .size(req_size), .bad(d_bad), .two_row(d_two),
    .lo_idx(d_lo_idx), .hi_idx(d_hi_idx), .byte_off(d_off)
  );

  fuse_win_seq #(.SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .refuse(refuse), .d_two(d_two),
    .d_lo_idx(d_lo_idx), .d_hi_idx(d_hi_idx), .d_off(d_off), .d_size(req_size),
    .row_rd_data(row_rd_data), .state(state), .row_rd_en(row_rd_en),
    .row_rd_idx(row_rd_idx), .lo_row(lo_row), .hi_row(hi_row), .two_q(two_q),
    .err_q(err_q), .off_q(off_q), .size_q(size_q)
  );

  fuse_win_align #(.SIZE_W(SIZE_W)) u_align (
    .lo_row(lo_row), .hi_row(hi_row), .two(two_q), .off(off_q),
    .size(size_q), .err(err_q), .data(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst)            flag_q <= 1'b0;
    else if (accept_wr) flag_q <= 1'b1;
  end

  assign guest_err = flag_q;
  assign rsp_valid = (state == FW_RESP);
  assign rsp_err   = rsp_valid && err_q;
  assign rsp_data  = rsp_valid ? aligned : '0;
endmodule

// File: rtl/fuse_win_checker.sv
module fuse_win_checker #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ROWS  = 768
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             accept_wr,
  input logic             accept_rd,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [31:0]      rsp_data,
  input logic             guest_err,
  input logic             row_rd_en,
  input logic [IDX_W-1:0] row_rd_idx
);
  assert_rsp_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_err_zero_data_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == 32'h0));

  assert_row_in_window_R1: assert property (@(posedge clk) disable iff (rst)
    row_rd_en |-> (32'(row_rd_idx) < ROWS));

  assert_fetch_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    row_rd_en |-> !req_ready);

  assert_write_no_fetch_R7: assert property (@(posedge clk) disable iff (rst)
    accept_wr |=> (!row_rd_en && rsp_valid && rsp_err));

  assert_flag_sets_R7: assert property (@(posedge clk) disable iff (rst)
    accept_wr |=> guest_err);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(guest_err) && !$past(rst)) |-> guest_err);

  assert_read_fetch_next_R3: assert property (@(posedge clk) disable iff (rst)
    accept_rd |=> (row_rd_en || (rsp_valid && rsp_err)));
endmodule

bind fuse_row_window fuse_win_checker #(
  .IDX_W(IDX_W), .ROWS(WIN_BYTES / 4)
) u_checker (
  .clk(clk), .rst(rst), .req_ready(req_ready), .accept_wr(accept_wr),
  .accept_rd(accept_rd), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_data(rsp_data), .guest_err(guest_err), .row_rd_en(row_rd_en),
  .row_rd_idx(row_rd_idx)
);

// File: tb/tb_fuse_row_window.sv
module tb_fuse_row_window;
  localparam int WIN = 3072;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_size = '0;
  logic        req_ready, rsp_valid, rsp_err, guest_err, row_rd_en;
  logic [31:0] rsp_data;
  logic [9:0]  row_rd_idx;
  logic [31:0] row_rd_data = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int rd_cnt   = 0;
  int idx_log [2];

  always #2 clk = ~clk;

  fuse_row_window dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .guest_err(guest_err), .row_rd_en(row_rd_en), .row_rd_idx(row_rd_idx),
    .row_rd_data(row_rd_data)
  );

  function automatic logic [31:0] row_val(input int i);
    logic [31:0] v;
    v = 32'(i + 1) * 32'h9E3779B9;
    return v ^ 32'(i * 13);
  endfunction

  function automatic logic [7:0] arr_byte(input int b);
    logic [31:0] r;
    r = row_val(b / 4);
    return r[8*(b%4) +: 8];
  endfunction

  // Row array model with one-cycle read latency.
  always @(posedge clk) begin
    if (row_rd_en) begin
      row_rd_data <= row_val(int'(row_rd_idx));
      if (rd_cnt < 2) idx_log[rd_cnt] = int'(row_rd_idx);
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic txn(input int addr, input int size, input bit wr);
    bit          exp_err, two;
    int          exp_lat, exp_rd, cyc, last;
    logic [31:0] exp_data;
    bit          busy_ok;
    last    = addr + size - 1;
    exp_err = wr || size < 1 || size > 4 || last >= WIN;
    two     = !exp_err && ((addr / 4) != (last / 4));
    exp_lat = exp_err ? 1 : (two ? 4 : 3);
    exp_rd  = exp_err ? 0 : (two ? 2 : 1);
    exp_data = '0;
    if (!exp_err)
      for (int k = 0; k < size; k++) exp_data[8*k +: 8] = arr_byte(addr + k);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_write = wr;
    req_addr = 16'(addr); req_size = 3'(size);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    busy_ok = 1'b1;
    while (!rsp_valid && cyc < 20) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (req_ready) busy_ok = 1'b0;
    check(cyc == exp_lat, "R8 latency", cyc, exp_lat);
    check(busy_ok, "R8 ready low while busy", 0, 1);
    check(rsp_err == exp_err, exp_err ? (wr ? "R7 err" : "R1/R2 err") : "R5 err", rsp_err, exp_err);
    check(rsp_data == exp_data, exp_err ? "R1 R2 zero data" : "R5 R6 data", rsp_data, exp_data);
    check(rd_cnt == exp_rd, "R4 row read count", rd_cnt, exp_rd);
    if (exp_rd >= 1) check(idx_log[0] == addr / 4, "R3 first row", idx_log[0], addr / 4);
    if (exp_rd == 2) check(idx_log[1] == last / 4, "R3 second row", idx_log[1], last / 4);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R8 single response", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !guest_err, "R9 reset state", {req_ready, rsp_valid, guest_err}, 3'b100);

    // R5 R6 R3 R4 R2: every offset across several rows, legal and illegal sizes
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 8; s++) txn(a, s, 1'b0);
    // R1: approach and cross the window end
    for (int a = WIN - 8; a < WIN + 4; a++)
      for (int s = 1; s <= 4; s++) txn(a, s, 1'b0);
    txn(16'hFFFC, 4, 1'b0);
    txn(16'hFFFF, 1, 1'b0);
    txn(16'h1234, 2, 1'b0);
    check(!guest_err, "R7 flag clear before write", guest_err, 0);

    // R7: writes refused, flag sticky, later reads still correct
    txn(5, 2, 1'b1);
    check(guest_err, "R7 flag set", guest_err, 1);
    txn(0, 4, 1'b0);
    txn(7, 3, 1'b0);
    txn(WIN + 8, 4, 1'b1);
    check(guest_err, "R7 flag sticky", guest_err, 1);

    // R9: reset clears the flag
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!guest_err && req_ready && !rsp_valid, "R9 reset after write",
          {req_ready, rsp_valid, guest_err}, 3'b100);
    txn(2, 4, 1'b0);
    report();
  end
endmodule